// File: doc/BRIEF.md
# Crossbar Sequencer Configuration Port (SPI Register Slave)

This block is the configuration and readback port of a crossbar-array pulse sequencer. An external host talks to it over a Mode-0 SPI link (clock idles low, data sampled on the rising edge, most significant bit first). Each transfer is two bytes long. The first byte is a command: its top bit selects write or read, and its lower seven bits give a register address. The second byte is either the value to store or, on a read, eight clocks during which the addressed register is shifted out on MISO.

The block holds the writable sequencer settings with their reset values: operating mode, cell row and column, a 9-bit pulse width, DAC code, sweep limits and step, repeat and gap counts, and compliance threshold. It drives these straight to the sequencer. Read-only values arrive from the sequencer as inputs and are presented at their addresses. These are the status flags, the 4-bit ADC sample, the 16-bit pulse counter split over two non-adjacent addresses, a half-value of the live DAC code, and the ADC sample from the final sweep step. A sticky 8-bit compliance history collects event bits until a self-clearing command bit empties it. SCK, MOSI and CS are brought into the system clock domain through two-flop synchronizers, and MISO is driven only while CS is low.

Top module: `spi_regbank`

## Requirements
- R1: After reset the pulse width is 10, the DAC code 0x80, sweep first 0x00, sweep last 0xFF, sweep step 0x10 and the compliance threshold 0xFF. Every other writable field is 0.
- R2: A command byte whose bit 7 is 1 writes the following byte, MSB first, to the register at address bits [6:0]. The value is applied once the sixteenth SCK rising edge has been seen.
- R3: A command byte whose bit 7 is 0 reads the register at address bits [6:0]. Its value appears on MISO MSB first and is valid at each of SCK rising edges 9 to 16.
- R4: spi_miso_oe is 0 whenever spi_cs_n is 1 and 1 whenever spi_cs_n is 0.
- R5: Control register 0x00 holds bit 0 start, bit 1 abort, bit 2 auto-sweep, bit 3 compliance enable and bit 4 clear-history. Writing start = 1 gives exactly one cycle of start_pulse. Bits 0 and 4 read back as 0, and bits 1 to 3 hold their written values.
- R6: Status at 0x07 reads {compliance_hit, 0, 0, 0, sense, error, done, busy}. Writes to it change nothing.
- R7: Address 0x08 reads {4'b0, adc_nib}. Row 0x02 and column 0x03 keep only bits [2:0]. Pulse width takes bits [7:0] from 0x04 and bit 8 from bit 0 of 0x05.
- R8: Address 0x0E reads pulse_count[7:0] and 0x11 reads pulse_count[15:8]. Address 0x0F reads {0, active_dac[7:1]}, and 0x12 reads sweep_last_adc.
- R9: Each hist_set bit ORs into comp_history (readable at 0x10) and stays set until clear-history is written. Clear-history empties it one cycle later.
- R10: Reads from addresses 0x13 to 0x7F return 0x00, and writes to them change no register.
- R11: Raising CS before the sixteenth rising edge discards the partial transfer with no register change. The next transfer then decodes normally.
- R12: Mode register 0x01 keeps bits [1:0]. Repeat register 0x0C gives repeat_count from bits [3:0] and gap_units from bits [7:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO pad |
| seq_busy | input | 1 | Sequencer busy flag |
| seq_done | input | 1 | Operation-complete flag |
| seq_error | input | 1 | Operation error flag |
| seq_comp_hit | input | 1 | Compliance trip flag |
| sense_in | input | 1 | Sense comparator level |
| adc_nib | input | 4 | Latest ADC sample |
| pulse_count | input | 16 | Delivered pulse count |
| active_dac | input | 8 | DAC code currently applied |
| sweep_last_adc | input | 8 | ADC sample from final sweep step |
| hist_set | input | 8 | Compliance history set bits |
| start_pulse | output | 1 | One-cycle start command |
| abort_req | output | 1 | Abort level |
| auto_sweep | output | 1 | Sweep mode enable |
| comp_en | output | 1 | Compliance abort enable |
| op_mode | output | 2 | Operation mode |
| row_sel | output | 3 | Row address |
| col_sel | output | 3 | Column address |
| pulse_width | output | 9 | Pulse width in cycles |
| dac_code | output | 8 | Programmed DAC code |
| sweep_first | output | 8 | Sweep start code |
| sweep_last | output | 8 | Sweep end code |
| sweep_step | output | 8 | Sweep increment |
| repeat_count | output | 4 | Pulse repeat count |
| gap_units | output | 4 | Inter-pulse gap in 16-cycle units |
| comp_threshold | output | 8 | Compliance ADC threshold |
| comp_history | output | 8 | Sticky compliance history |

## Verification
The assertions assume that the host's SCK high and low phases each last several system clocks, so that every synchronized edge is seen as a separate event. They also assume CS moves only while SCK is low and well apart from any SCK edge, and that no two register writes complete in consecutive cycles. The bench drives SCK with an eight-cycle half period, changes MOSI and CS only at SCK low with a half period of slack, and changes the sequencer-side inputs on the falling system clock edge. That keeps every transfer inside those limits, including the deliberately cut-short one.

// File: rtl/spireg_pkg.sv
package spireg_pkg;
    localparam int DW          = 8;
    localparam int AW          = 7;
    localparam int PW_W        = 9;
    localparam int RC_W        = 3;
    localparam int ADC_W       = 4;
    localparam int CNT_W       = 16;
    localparam int SYNC_STAGES = 2;
    localparam int FRAME_BITS  = 2 * DW;
    localparam int FCNT_W      = $clog2(FRAME_BITS);

    localparam logic [AW-1:0] A_CTRL     = 7'h00;
    localparam logic [AW-1:0] A_MODE     = 7'h01;
    localparam logic [AW-1:0] A_ROW      = 7'h02;
    localparam logic [AW-1:0] A_COL      = 7'h03;
    localparam logic [AW-1:0] A_PW_LO    = 7'h04;
    localparam logic [AW-1:0] A_PW_HI    = 7'h05;
    localparam logic [AW-1:0] A_DAC      = 7'h06;
    localparam logic [AW-1:0] A_STATUS   = 7'h07;
    localparam logic [AW-1:0] A_ADC      = 7'h08;
    localparam logic [AW-1:0] A_SW_FIRST = 7'h09;
    localparam logic [AW-1:0] A_SW_LAST  = 7'h0A;
    localparam logic [AW-1:0] A_SW_STEP  = 7'h0B;
    localparam logic [AW-1:0] A_REPEAT   = 7'h0C;
    localparam logic [AW-1:0] A_COMP     = 7'h0D;
    localparam logic [AW-1:0] A_CNT_LO   = 7'h0E;
    localparam logic [AW-1:0] A_HALF     = 7'h0F;
    localparam logic [AW-1:0] A_HIST     = 7'h10;
    localparam logic [AW-1:0] A_CNT_HI   = 7'h11;
    localparam logic [AW-1:0] A_SW_ADC   = 7'h12;
    localparam logic [AW-1:0] A_FIRST_UNMAPPED = 7'h13;

    typedef struct packed {
        logic            abort;
        logic            auto_sweep;
        logic            comp_en;
        logic [1:0]      mode;
        logic [RC_W-1:0] row;
        logic [RC_W-1:0] col;
        logic [PW_W-1:0] pw;
        logic [DW-1:0]   dac;
        logic [DW-1:0]   sw_first;
        logic [DW-1:0]   sw_last;
        logic [DW-1:0]   sw_step;
        logic [DW-1:0]   rep;
        logic [DW-1:0]   comp_thr;
    } cfg_t;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             error;
        logic             comp_hit;
        logic             sense;
        logic [ADC_W-1:0] adc;
        logic [CNT_W-1:0] pcount;
        logic [DW-1:0]    act_dac;
        logic [DW-1:0]    sweep_adc;
    } stat_t;

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c          = '0;
        c.pw       = PW_W'(10);
        c.dac      = 8'h80;
        c.sw_first = 8'h00;
        c.sw_last  = 8'hFF;
        c.sw_step  = 8'h10;
        c.comp_thr = 8'hFF;
        return c;
    endfunction

    function automatic logic [DW-1:0] status_byte(stat_t s);
        return {s.comp_hit, 3'b000, s.sense, s.error, s.done, s.busy};
    endfunction
endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sck_s,
    input  logic          csn_s,
    input  logic          mosi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          miso_bit
);
    localparam logic [FCNT_W-1:0] LAST_CMD    = FCNT_W'(DW - 1);
    localparam logic [FCNT_W-1:0] LAST_DATA   = FCNT_W'(FRAME_BITS - 1);
    localparam logic [FCNT_W-1:0] FIRST_SHIFT = FCNT_W'(DW + 1);
    localparam logic [FCNT_W-1:0] HOLD_BIT    = FCNT_W'(DW);

    logic              sck_d;
    logic [FCNT_W-1:0] bit_cnt;
    logic [DW-2:0]     rx_sh;
    logic [DW-1:0]     cmd_q;
    logic [DW-1:0]     tx_sh;
    logic              sck_rise, sck_fall;

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign rd_addr  = {rx_sh[DW-3:0], mosi_s};
    assign miso_bit = tx_sh[DW-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d   <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            cmd_q   <= '0;
            tx_sh   <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            sck_d  <= sck_s;
            wr_stb <= 1'b0;
            if (csn_s) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else if (sck_rise) begin
                rx_sh   <= {rx_sh[DW-3:0], mosi_s};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_CMD) begin
                    cmd_q <= {rx_sh, mosi_s};
                    tx_sh <= rx_sh[DW-2] ? '0 : rd_data;
                end
                if (bit_cnt == LAST_DATA && cmd_q[DW-1]) begin
                    wr_stb  <= 1'b1;
                    wr_addr <= cmd_q[AW-1:0];
                    wr_data <= {rx_sh, mosi_s};
                end
            end else if (sck_fall && bit_cnt >= FIRST_SHIFT) begin
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
        end
    end

    assert_cs_discards_R11: assert property (@(posedge clk) disable iff (rst)
        csn_s |=> (bit_cnt == '0 && !wr_stb));

    assert_msb_held_R3: assert property (@(posedge clk) disable iff (rst)
        (sck_fall && !csn_s && bit_cnt == HOLD_BIT) |=> $stable(tx_sh));

    assert_write_needs_cmd_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> cmd_q[DW-1]);
endmodule

// File: rtl/spireg_regs.sv
module spireg_regs
    import spireg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  stat_t         stat,
    input  logic [DW-1:0] hist_set,
    output logic [DW-1:0] rd_data,
    output cfg_t          cfg_q,
    output logic          start_q,
    output logic [DW-1:0] hist_q
);
    logic clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= cfg_reset();
            start_q <= 1'b0;
            clr_q   <= 1'b0;
            hist_q  <= '0;
        end else begin
            start_q <= 1'b0;
            clr_q   <= 1'b0;
            hist_q  <= (clr_q ? '0 : hist_q) | hist_set;
            if (wr_stb) begin
                case (wr_addr)
                    A_CTRL: begin
                        start_q          <= wr_data[0];
                        cfg_q.abort      <= wr_data[1];
                        cfg_q.auto_sweep <= wr_data[2];
                        cfg_q.comp_en    <= wr_data[3];
                        clr_q            <= wr_data[4];
                    end
                    A_MODE:     cfg_q.mode     <= wr_data[1:0];
                    A_ROW:      cfg_q.row      <= wr_data[RC_W-1:0];
                    A_COL:      cfg_q.col      <= wr_data[RC_W-1:0];
                    A_PW_LO:    cfg_q.pw[DW-1:0] <= wr_data;
                    A_PW_HI:    cfg_q.pw[PW_W-1] <= wr_data[0];
                    A_DAC:      cfg_q.dac      <= wr_data;
                    A_SW_FIRST: cfg_q.sw_first <= wr_data;
                    A_SW_LAST:  cfg_q.sw_last  <= wr_data;
                    A_SW_STEP:  cfg_q.sw_step  <= wr_data;
                    A_REPEAT:   cfg_q.rep      <= wr_data;
                    A_COMP:     cfg_q.comp_thr <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:     rd_data = {3'b000, clr_q, cfg_q.comp_en, cfg_q.auto_sweep,
                                   cfg_q.abort, start_q};
            A_MODE:     rd_data = {6'b0, cfg_q.mode};
            A_ROW:      rd_data = {{(DW-RC_W){1'b0}}, cfg_q.row};
            A_COL:      rd_data = {{(DW-RC_W){1'b0}}, cfg_q.col};
            A_PW_LO:    rd_data = cfg_q.pw[DW-1:0];
            A_PW_HI:    rd_data = {{(DW-1){1'b0}}, cfg_q.pw[PW_W-1]};
            A_DAC:      rd_data = cfg_q.dac;
            A_STATUS:   rd_data = status_byte(stat);
            A_ADC:      rd_data = {{(DW-ADC_W){1'b0}}, stat.adc};
            A_SW_FIRST: rd_data = cfg_q.sw_first;
            A_SW_LAST:  rd_data = cfg_q.sw_last;
            A_SW_STEP:  rd_data = cfg_q.sw_step;
            A_REPEAT:   rd_data = cfg_q.rep;
            A_COMP:     rd_data = cfg_q.comp_thr;
            A_CNT_LO:   rd_data = stat.pcount[DW-1:0];
            A_HALF:     rd_data = {1'b0, stat.act_dac[DW-1:1]};
            A_HIST:     rd_data = hist_q;
            A_CNT_HI:   rd_data = stat.pcount[CNT_W-1:DW];
            A_SW_ADC:   rd_data = stat.sweep_adc;
            default:    rd_data = '0;
        endcase
    end

    assert_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == cfg_reset() && hist_q == '0 && !start_q));

    assert_start_single_R5: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    assert_status_readonly_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr == A_STATUS) |=> $stable(cfg_q));

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_addr >= A_FIRST_UNMAPPED) |=> $stable(cfg_q));

    assert_hist_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_q |=> ((hist_q & $past(hist_q)) == $past(hist_q)));
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_oe,
    input  logic             seq_busy,
    input  logic             seq_done,
    input  logic             seq_error,
    input  logic             seq_comp_hit,
    input  logic             sense_in,
    input  logic [ADC_W-1:0] adc_nib,
    input  logic [CNT_W-1:0] pulse_count,
    input  logic [DW-1:0]    active_dac,
    input  logic [DW-1:0]    sweep_last_adc,
    input  logic [DW-1:0]    hist_set,
    output logic             start_pulse,
    output logic             abort_req,
    output logic             auto_sweep,
    output logic             comp_en,
    output logic [1:0]       op_mode,
    output logic [RC_W-1:0]  row_sel,
    output logic [RC_W-1:0]  col_sel,
    output logic [PW_W-1:0]  pulse_width,
    output logic [DW-1:0]    dac_code,
    output logic [DW-1:0]    sweep_first,
    output logic [DW-1:0]    sweep_last,
    output logic [DW-1:0]    sweep_step,
    output logic [3:0]       repeat_count,
    output logic [3:0]       gap_units,
    output logic [DW-1:0]    comp_threshold,
    output logic [DW-1:0]    comp_history
);
    logic          sck_s, csn_s, mosi_s;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data;
    logic          wr_stb;
    cfg_t          cfg;
    stat_t         stat;

    spireg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sck, spi_cs_n, spi_mosi}),
        .q   ({sck_s, csn_s, mosi_s})
    );

    spireg_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sck_s),
        .csn_s    (csn_s),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .miso_bit (spi_miso)
    );

    assign stat = '{busy: seq_busy, done: seq_done, error: seq_error,
                    comp_hit: seq_comp_hit, sense: sense_in, adc: adc_nib,
                    pcount: pulse_count, act_dac: active_dac,
                    sweep_adc: sweep_last_adc};

    spireg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .stat     (stat),
        .hist_set (hist_set),
        .rd_data  (rd_data),
        .cfg_q    (cfg),
        .start_q  (start_pulse),
        .hist_q   (comp_history)
    );

    assign spi_miso_oe    = ~spi_cs_n;
    assign abort_req      = cfg.abort;
    assign auto_sweep     = cfg.auto_sweep;
    assign comp_en        = cfg.comp_en;
    assign op_mode        = cfg.mode;
    assign row_sel        = cfg.row;
    assign col_sel        = cfg.col;
    assign pulse_width    = cfg.pw;
    assign dac_code       = cfg.dac;
    assign sweep_first    = cfg.sw_first;
    assign sweep_last     = cfg.sw_last;
    assign sweep_step     = cfg.sw_step;
    assign repeat_count   = cfg.rep[3:0];
    assign gap_units      = cfg.rep[7:4];
    assign comp_threshold = cfg.comp_thr;

    assert_miso_quiet_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (csn_s && $past(csn_s)) |-> !spi_miso);
endmodule

// File: tb/tb_spi_regbank.sv
module tb_spi_regbank;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe;
    logic seq_busy = 0, seq_done = 0, seq_error = 0, seq_comp_hit = 0, sense_in = 0;
    logic [3:0]  adc_nib = 0;
    logic [15:0] pulse_count = 0;
    logic [7:0]  active_dac = 0, sweep_last_adc = 0, hist_set = 0;
    logic start_pulse, abort_req, auto_sweep, comp_en;
    logic [1:0] op_mode;
    logic [2:0] row_sel, col_sel;
    logic [8:0] pulse_width;
    logic [7:0] dac_code, sweep_first, sweep_last, sweep_step, comp_threshold, comp_history;
    logic [3:0] repeat_count, gap_units;

    int total = 0, bad = 0, start_seen = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_byte;
    event       rx_done;
    bit         finished = 0;

    always #5 clk = ~clk;

    spi_regbank dut (.*);

    always @(posedge clk) if (start_pulse) start_seen++;

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(logic [15:0] frame, int nbits, output logic [7:0] rx);
        rx = 8'h00;
        spi_cs_n = 1'b0;
        wait_clk(H);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = frame[15-i];
            wait_clk(H);
            if (i >= 8) rx = {rx[6:0], spi_miso};
            spi_sck = 1'b1;
            wait_clk(H);
            spi_sck = 1'b0;
        end
        wait_clk(H);
        spi_cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic spi_write(logic [6:0] a, logic [7:0] d);
        logic [7:0] dummy;
        spi_bits({1'b1, a, d}, 16, dummy);
    endtask

    task automatic spi_read(logic [6:0] a, logic [7:0] exp, string tag);
        logic [7:0] r;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        spi_bits({1'b0, a, 8'h00}, 16, r);
        rx_byte = r;
        -> rx_done;
        wait_clk(2);
    endtask

    initial begin : monitor
        forever begin
            @(rx_done);
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty actual=%h expected=none", rx_byte);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rx_byte !== e) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", t, rx_byte, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin : driver
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        // R1 reset state
        chk("R1 pulse_width port", 16'(pulse_width), 16'd10);
        chk("R1 dac port", 16'(dac_code), 16'h80);
        chk("R4 oe idle", 16'(spi_miso_oe), 16'd0);
        spi_read(7'h04, 8'h0A, "R1 pw lo");
        spi_read(7'h05, 8'h00, "R1 pw hi");
        spi_read(7'h06, 8'h80, "R1 dac");
        spi_read(7'h09, 8'h00, "R1 sweep first");
        spi_read(7'h0A, 8'hFF, "R1 sweep last");
        spi_read(7'h0B, 8'h10, "R1 sweep step");
        spi_read(7'h0D, 8'hFF, "R1 threshold");
        spi_read(7'h00, 8'h00, "R1 ctrl");
        // R4 oe while selected
        spi_cs_n = 1'b0;
        wait_clk(2);
        chk("R4 oe selected", 16'(spi_miso_oe), 16'd1);
        spi_cs_n = 1'b1;
        wait_clk(H);
        // R2 R3 write/readback
        spi_write(7'h06, 8'hA5);
        chk("R2 dac port", 16'(dac_code), 16'hA5);
        spi_read(7'h06, 8'hA5, "R3 dac readback");
        spi_write(7'h0B, 8'h3C);
        spi_read(7'h0B, 8'h3C, "R3 step readback");
        // R12 mode and repeat
        spi_write(7'h01, 8'hFF);
        spi_read(7'h01, 8'h03, "R12 mode");
        spi_write(7'h0C, 8'h34);
        chk("R12 repeat_count", 16'(repeat_count), 16'd4);
        chk("R12 gap_units", 16'(gap_units), 16'd3);
        // R7 widths
        spi_write(7'h02, 8'hFF);
        spi_read(7'h02, 8'h07, "R7 row");
        spi_write(7'h03, 8'h0D);
        chk("R7 col port", 16'(col_sel), 16'd5);
        spi_write(7'h04, 8'h32);
        spi_write(7'h05, 8'hFF);
        spi_read(7'h05, 8'h01, "R7 pw hi");
        chk("R7 pulse_width port", 16'(pulse_width), 16'h132);
        adc_nib = 4'hC;
        spi_read(7'h08, 8'h0C, "R7 adc");
        // R6 status
        seq_comp_hit = 1; sense_in = 1; seq_error = 0; seq_done = 1; seq_busy = 0;
        spi_read(7'h07, 8'h8A, "R6 status");
        spi_write(7'h07, 8'h00);
        spi_read(7'h07, 8'h8A, "R6 status after write");
        seq_comp_hit = 0; sense_in = 0; seq_error = 1; seq_done = 0; seq_busy = 1;
        spi_read(7'h07, 8'h05, "R6 status other bits");
        chk("R6 dac untouched", 16'(dac_code), 16'hA5);
        // R8 counter, half, sweep adc
        pulse_count = 16'hBEEF; active_dac = 8'h9B; sweep_last_adc = 8'h5A;
        spi_read(7'h0E, 8'hEF, "R8 count lo");
        spi_read(7'h11, 8'hBE, "R8 count hi");
        spi_read(7'h0F, 8'h4D, "R8 half dac");
        spi_read(7'h12, 8'h5A, "R8 sweep adc");
        // R10 unmapped
        spi_read(7'h13, 8'h00, "R10 read 0x13");
        spi_write(7'h7F, 8'h55);
        spi_read(7'h7F, 8'h00, "R10 read 0x7F");
        spi_read(7'h06, 8'hA5, "R10 dac unchanged");
        // R5 control
        start_seen = 0;
        spi_write(7'h00, 8'h0F);
        wait_clk(4);
        chk("R5 start pulse count", 16'(start_seen), 16'd1);
        chk("R5 abort level", 16'(abort_req), 16'd1);
        chk("R5 auto_sweep", 16'(auto_sweep), 16'd1);
        chk("R5 comp_en", 16'(comp_en), 16'd1);
        spi_read(7'h00, 8'h0E, "R5 ctrl readback");
        // R9 history
        hist_set = 8'h21;
        wait_clk(1);
        hist_set = 8'h00;
        wait_clk(3);
        spi_read(7'h10, 8'h21, "R9 hist first");
        hist_set = 8'h04;
        wait_clk(1);
        hist_set = 8'h00;
        wait_clk(1);
        chk("R9 hist port", 16'(comp_history), 16'h25);
        spi_write(7'h00, 8'h10);
        wait_clk(2);
        chk("R9 hist cleared", 16'(comp_history), 16'h00);
        spi_read(7'h00, 8'h00, "R5 clear bit self-clears");
        spi_read(7'h10, 8'h00, "R9 hist read cleared");
        // R11 cut-short transfer
        begin
            logic [7:0] dummy;
            spi_bits({1'b1, 7'h06, 8'h11}, 12, dummy);
        end
        chk("R11 dac after abort", 16'(dac_code), 16'hA5);
        spi_read(7'h06, 8'hA5, "R11 dac readback");
        spi_write(7'h0D, 8'h40);
        chk("R11 next write ok", 16'(comp_threshold), 16'h40);
        wait_clk(4);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        report();
    end
endmodule